// File: doc/BRIEF.md
# I2C Controller Register Front End

This block is the memory-mapped register layer that sits between a processor bus and an I2C master engine. It decodes a small set of word-aligned offsets. Offset 0x00 is a shared data port: a write pushes a command word into the transmit FIFO, and a read pops a received byte from the receive FIFO. The other offsets hold a status word, a control word, two 10-bit SCL timing dividers, the two FIFO fill levels and two byte counters.

The engine pulls command words from the transmit FIFO, pushes received bytes into the receive FIFO and reports its events to this block. The block keeps the sticky event flags, merges every event with its enable bit into one interrupt line, and runs a soft reset. Software starts the reset by setting a control bit. That bit stays set while the FIFOs, counters and flags are flushed and the engine is told to abort, then it clears itself, so software can poll it.

The bus side is a plain strobe interface. Read data is combinational from the offset and is valid in the same cycle as `bus_rd_i`. The FIFO pop takes place at the clock edge that ends the strobe cycle.

Top module: `i2c_regfile`

## Requirements
- R1: A write to offset 0x00 pushes wdata[9:0] into the transmit FIFO, with the byte in bits 7:0, a start request in bit 8 and a stop request in bit 9. The engine sees the words in push order on `eng_tx_data_o`, with `eng_tx_valid_o` high while the FIFO holds a word. A write while the FIFO is full is dropped.
- R2: A read of offset 0x00 returns the oldest received byte in bits 7:0 and pops it. A read while the receive FIFO is empty returns 0 and leaves the level unchanged. An engine push into a full receive FIFO is dropped.
- R3: Status at 0x04 holds the following bits: transfer-done flag in bit 0, arbitration-lost flag in bit 1, nack in bit 2, need-data in bit 3, engine active in bit 5, SCL in bit 6, SDA in bit 7, RX full in bit 8, RX empty in bit 9, TX full in bit 10 and TX empty in bit 11. All other bits read 0.
- R4: The transfer-done and arbitration-lost flags are set by one-cycle engine pulses and stay set. Writing 1 to bit 0 or bit 1 of 0x04 clears only that flag.
- R5: Status bits 2 and 3 follow the engine's nack and need-data levels. Writes to 0x04 do not change them, and they read 0 while a soft reset is in progress.
- R6: Control at 0x08 stores bits 7:0 as interrupt enables and reads them back. From bit 0 upward the enables are: transfer-done, arbitration-lost, nack, need-data, slave-request (stored only), RX full, RX not empty and TX full.
- R7: Writing 1 to control bit 8 starts a soft reset. Bit 8 then reads 1 for RST_CYCLES cycles and afterwards reads 0. While the reset runs, both FIFOs are emptied, both counters are cleared, both sticky flags are cleared, `eng_abort_o` is high and writes to the TX port are dropped. The enable bits are kept.
- R8: `irq_o` is high exactly when at least one source is active together with its enable. The sources are the two sticky flags, nack, need-data, RX not empty, RX full and TX full.
- R9: The clock-low divider at 0x0C and the clock-high divider at 0x10 store wdata[9:0] and discard the higher bits. They read back and drive `clk_lo_o` and `clk_hi_o`.
- R10: Offset 0x18 reads the RX FIFO level and offset 0x1C reads the TX FIFO level.
- R11: Offset 0x20 counts every byte the engine delivers to the receive side, including bytes dropped when the FIFO is full. Offset 0x24 counts every word the engine takes from a non-empty transmit FIFO.
- R12: Offsets that are not mapped read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 6 | Byte offset (word aligned) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset |
| eng_tx_valid_o | output | 1 | Transmit FIFO holds a word |
| eng_tx_data_o | output | 10 | Oldest transmit word {stop, start, byte} |
| eng_tx_pop_i | input | 1 | Engine takes the oldest transmit word |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| eng_done_i | input | 1 | Transfer-done pulse |
| eng_arb_lost_i | input | 1 | Arbitration-lost pulse |
| eng_nack_i | input | 1 | Nack level |
| eng_need_data_i | input | 1 | Need-data level |
| eng_active_i | input | 1 | Engine owns the bus |
| scl_i | input | 1 | Sampled SCL |
| sda_i | input | 1 | Sampled SDA |
| eng_abort_o | output | 1 | Abort request during soft reset |
| clk_hi_o | output | 10 | SCL high divider |
| clk_lo_o | output | 10 | SCL low divider |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions check these properties on every cycle:
- FIFO levels stay within their bounds.
- A push into a full FIFO leaves its level unchanged.
- An engine pulse always lands in its sticky flag outside reset.
- A running soft reset empties both FIFOs by the next cycle and masks the level events.
- An enabled active source always raises the interrupt.

Some behaviour depends on what software wrote earlier, and only the bench's scenarios show it:
- the order and content of the transmit words;
- the empty-read value;
- write-one-to-clear acting on a single bit;
- the 10-bit truncation of the dividers;
- the self-clearing reset bit read back over time;
- the exact counter values after mixed random traffic.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;
  localparam int OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_FIFO  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_STAT  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_CLKLO = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_CLKHI = 6'h10;
  localparam logic [OFS_W-1:0] OFS_RXLVL = 6'h18;
  localparam logic [OFS_W-1:0] OFS_TXLVL = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_RXCNT = 6'h20;
  localparam logic [OFS_W-1:0] OFS_TXCNT = 6'h24;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_ARB  = 1;
  localparam int ST_NACK = 2;
  localparam int ST_NEED = 3;
  localparam int ST_ACT  = 5;
  localparam int ST_SCL  = 6;
  localparam int ST_SDA  = 7;
  localparam int ST_RXF  = 8;
  localparam int ST_RXE  = 9;
  localparam int ST_TXF  = 10;
  localparam int ST_TXE  = 11;

  // control bit positions
  localparam int CT_DONE = 0;
  localparam int CT_ARB  = 1;
  localparam int CT_NACK = 2;
  localparam int CT_NEED = 3;
  localparam int CT_SLV  = 4;
  localparam int CT_RXF  = 5;
  localparam int CT_RXNE = 6;
  localparam int CT_TXF  = 7;
  localparam int CT_RST  = 8;
  localparam int CT_EN_W = 8;

  localparam int TXW_W = 10;
  localparam int RXW_W = 8;

  typedef struct packed {
    logic tx_full;
    logic rx_ne;
    logic rx_full;
    logic need;
    logic nack;
    logic arb;
    logic done;
  } irq_vec_t;
  localparam int IRQ_N = $bits(irq_vec_t);
endpackage

// File: rtl/i2c_sync_fifo.sv
module i2c_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] lvl_q;
  logic             do_push, do_pop;

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign level_o = lvl_q;
  assign head_o  = mem_q[rptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q] <= wdata_i;
  end

  // R1
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));
  // R1
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (level_o == LVL_W'(DEPTH)));
endmodule

// File: rtl/i2c_reset_seq.sv
module i2c_reset_seq #(
  parameter int RST_CYCLES = 8,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(RST_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R7
  reset_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/i2c_irq_merge.sv
module i2c_irq_merge
  import i2c_regs_pkg::*;
(
  input  irq_vec_t src_i,
  input  irq_vec_t en_i,
  output logic     irq_o
);
  logic [IRQ_N-1:0] hit;
  for (genvar i = 0; i < IRQ_N; i++) begin : g_hit
    assign hit[i] = src_i[i] & en_i[i];
  end
  assign irq_o = |hit;
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile
  import i2c_regs_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int RST_CYCLES = 8,
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 10,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [5:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             eng_tx_valid_o,
  output logic [9:0]       eng_tx_data_o,
  input  logic             eng_tx_pop_i,
  input  logic             eng_rx_push_i,
  input  logic [7:0]       eng_rx_data_i,
  input  logic             eng_done_i,
  input  logic             eng_arb_lost_i,
  input  logic             eng_nack_i,
  input  logic             eng_need_data_i,
  input  logic             eng_active_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             eng_abort_o,
  output logic [DIV_W-1:0] clk_hi_o,
  output logic [DIV_W-1:0] clk_lo_o,
  output logic             irq_o
);
  logic busy;
  logic wr_fifo, rd_fifo, wr_stat, wr_ctrl, wr_lo, wr_hi;

  assign wr_fifo = bus_wr_i && (bus_addr_i == OFS_FIFO);
  assign rd_fifo = bus_rd_i && (bus_addr_i == OFS_FIFO);
  assign wr_stat = bus_wr_i && (bus_addr_i == OFS_STAT);
  assign wr_ctrl = bus_wr_i && (bus_addr_i == OFS_CTRL);
  assign wr_lo   = bus_wr_i && (bus_addr_i == OFS_CLKLO);
  assign wr_hi   = bus_wr_i && (bus_addr_i == OFS_CLKHI);

  i2c_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_ctrl && bus_wdata_i[CT_RST]),
    .busy_o  (busy)
  );
  assign eng_abort_o = busy;

  // FIFOs
  logic [TXW_W-1:0] tx_head;
  logic [RXW_W-1:0] rx_head;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic             tx_take, rx_give;

  assign tx_take = eng_tx_pop_i && !busy;
  assign rx_give = eng_rx_push_i && !busy;

  i2c_sync_fifo #(.W(TXW_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (busy),
    .push_i  (wr_fifo && !busy),
    .wdata_i (bus_wdata_i[TXW_W-1:0]),
    .pop_i   (tx_take),
    .head_o  (tx_head),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .level_o (tx_lvl)
  );

  i2c_sync_fifo #(.W(RXW_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (busy),
    .push_i  (rx_give),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rd_fifo && !busy),
    .head_o  (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .level_o (rx_lvl)
  );

  assign eng_tx_valid_o = !tx_empty && !busy;
  assign eng_tx_data_o  = tx_head;

  // sticky flags: bit0 done, bit1 arbitration lost
  logic [1:0] flag_q;
  logic [1:0] flag_set;
  assign flag_set = {eng_arb_lost_i, eng_done_i};

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flag_q[i] <= 1'b0;
      else if (busy)                      flag_q[i] <= 1'b0;
      else if (flag_set[i])               flag_q[i] <= 1'b1;
      else if (wr_stat && bus_wdata_i[i]) flag_q[i] <= 1'b0;
    end
  end

  logic nack_eff, need_eff;
  assign nack_eff = eng_nack_i && !busy;
  assign need_eff = eng_need_data_i && !busy;

  // control and dividers
  logic [CT_EN_W-1:0] en_q;
  logic [DIV_W-1:0]   lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata_i[CT_EN_W-1:0];
      if (wr_lo)   lo_q <= bus_wdata_i[DIV_W-1:0];
      if (wr_hi)   hi_q <= bus_wdata_i[DIV_W-1:0];
    end
  end
  assign clk_lo_o = lo_q;
  assign clk_hi_o = hi_q;

  // byte counters
  logic [CNT_W-1:0] rx_cnt_q, tx_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt_q <= '0;
      tx_cnt_q <= '0;
    end else if (busy) begin
      rx_cnt_q <= '0;
      tx_cnt_q <= '0;
    end else begin
      if (rx_give)              rx_cnt_q <= rx_cnt_q + 1'b1;
      if (tx_take && !tx_empty) tx_cnt_q <= tx_cnt_q + 1'b1;
    end
  end

  // status word
  logic [31:0] stat_w;
  always_comb begin
    stat_w          = '0;
    stat_w[ST_DONE] = flag_q[0];
    stat_w[ST_ARB]  = flag_q[1];
    stat_w[ST_NACK] = nack_eff;
    stat_w[ST_NEED] = need_eff;
    stat_w[ST_ACT]  = eng_active_i;
    stat_w[ST_SCL]  = scl_i;
    stat_w[ST_SDA]  = sda_i;
    stat_w[ST_RXF]  = rx_full;
    stat_w[ST_RXE]  = rx_empty;
    stat_w[ST_TXF]  = tx_full;
    stat_w[ST_TXE]  = tx_empty;
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_FIFO:  bus_rdata_o = rx_empty ? 32'd0 : 32'(rx_head);
      OFS_STAT:  bus_rdata_o = stat_w;
      OFS_CTRL:  bus_rdata_o = {23'd0, busy, en_q};
      OFS_CLKLO: bus_rdata_o = 32'(lo_q);
      OFS_CLKHI: bus_rdata_o = 32'(hi_q);
      OFS_RXLVL: bus_rdata_o = 32'(rx_lvl);
      OFS_TXLVL: bus_rdata_o = 32'(tx_lvl);
      OFS_RXCNT: bus_rdata_o = 32'(rx_cnt_q);
      OFS_TXCNT: bus_rdata_o = 32'(tx_cnt_q);
      default:   bus_rdata_o = '0;
    endcase
  end

  // interrupt
  irq_vec_t src, en;
  assign src = '{tx_full: tx_full, rx_ne: !rx_empty, rx_full: rx_full,
                 need: need_eff, nack: nack_eff, arb: flag_q[1], done: flag_q[0]};
  assign en  = '{tx_full: en_q[CT_TXF], rx_ne: en_q[CT_RXNE], rx_full: en_q[CT_RXF],
                 need: en_q[CT_NEED], nack: en_q[CT_NACK], arb: en_q[CT_ARB],
                 done: en_q[CT_DONE]};

  i2c_irq_merge u_irq (
    .src_i (src),
    .en_i  (en),
    .irq_o (irq_o)
  );

  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && !busy && !wr_ctrl) |=> flag_q[0]);
  // R4
  arb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_arb_lost_i && !busy && !wr_ctrl) |=> flag_q[1]);
  // R7
  reset_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (tx_lvl == '0 && rx_lvl == '0));
  // R5
  level_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (stat_w[ST_NACK] == 1'b0 && stat_w[ST_NEED] == 1'b0));
  // R8
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q[0] && en_q[CT_DONE]) || (!rx_empty && en_q[CT_RXNE])) |-> irq_o);
endmodule

// File: tb/tb_i2c_regfile.sv
module tb_i2c_regfile;
  localparam int DEPTH = 4;
  localparam int RSTC  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_valid;
  logic [9:0]  tx_data;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        done = 1'b0, arb = 1'b0, nack = 1'b0, need = 1'b0;
  logic        active = 1'b0, scl = 1'b1, sda = 1'b1;
  logic        abort;
  logic [9:0]  clk_hi, clk_lo;
  logic        irq;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  i2c_regfile #(.FIFO_DEPTH(DEPTH), .RST_CYCLES(RSTC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_pop_i(tx_pop),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data), .eng_done_i(done),
    .eng_arb_lost_i(arb), .eng_nack_i(nack), .eng_need_data_i(need),
    .eng_active_i(active), .scl_i(scl), .sda_i(sda), .eng_abort_o(abort),
    .clk_hi_o(clk_hi), .clk_lo_o(clk_lo), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic eng_take(output logic [9:0] d, output logic v);
    @(negedge clk); d = tx_data; v = tx_valid; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic eng_give(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
  endtask

  task automatic pulse_arb();
    @(negedge clk); arb = 1'b1; @(negedge clk); arb = 1'b0;
  endtask

  function automatic logic exp_irq(input logic [7:0] en, input int rxn, input int txn);
    return (en[6] && rxn > 0) || (en[5] && rxn == DEPTH) || (en[7] && txn == DEPTH);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [9:0]  td;
    logic        tv;
    logic [9:0]  txq[$];
    logic [7:0]  rxq[$];
    int          rxcnt, txcnt;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: R3 R6
    bus_rd(6'h04, r); chk("R3 reset status", r, 32'h0000_0AC0);
    bus_rd(6'h08, r); chk("R6 reset ctrl", r, 32'h0);
    chk("R8 reset irq", 32'(irq), 32'h0);

    // R9 dividers
    bus_wr(6'h0C, 32'h0001_2345);
    bus_wr(6'h10, 32'h0000_FFFF);
    bus_rd(6'h0C, r); chk("R9 clk low", r, 32'h345);
    bus_rd(6'h10, r); chk("R9 clk high", r, 32'h3FF);
    chk("R9 clk_lo_o", 32'(clk_lo), 32'h345);
    chk("R9 clk_hi_o", 32'(clk_hi), 32'h3FF);

    // R1 TX push order, full drop
    bus_wr(6'h00, 32'h1A5);
    bus_wr(6'h00, 32'h022);
    bus_wr(6'h00, 32'h2C3);
    bus_wr(6'h00, 32'h044);
    bus_wr(6'h00, 32'h055);
    bus_rd(6'h1C, r); chk("R10 tx level full", r, 32'd4);
    bus_rd(6'h04, r); chk("R3 tx full bits", r & 32'hC00, 32'h400);
    eng_take(td, tv); chk("R1 word0", {21'd0, tv, td}, {21'd0, 1'b1, 10'h1A5});
    eng_take(td, tv); chk("R1 word1", {21'd0, tv, td}, {21'd0, 1'b1, 10'h022});
    eng_take(td, tv); chk("R1 word2", {21'd0, tv, td}, {21'd0, 1'b1, 10'h2C3});
    eng_take(td, tv); chk("R1 word3", {21'd0, tv, td}, {21'd0, 1'b1, 10'h044});
    eng_take(td, tv); chk("R1 empty valid", 32'(tv), 32'h0);
    bus_rd(6'h24, r); chk("R11 tx count", r, 32'd4);

    // R2 RX
    bus_rd(6'h00, r); chk("R2 empty read", r, 32'h0);
    bus_rd(6'h18, r); chk("R2 empty level", r, 32'h0);
    eng_give(8'h11);
    eng_give(8'h22);
    bus_rd(6'h18, r); chk("R10 rx level", r, 32'd2);
    bus_rd(6'h00, r); chk("R2 rx first", r, 32'h11);
    bus_rd(6'h00, r); chk("R2 rx second", r, 32'h22);
    bus_rd(6'h00, r); chk("R2 rx drained", r, 32'h0);
    bus_rd(6'h20, r); chk("R11 rx count", r, 32'd2);

    // R4 sticky W1C
    pulse_done();
    bus_rd(6'h04, r); chk("R4 done set", r & 32'h3, 32'h1);
    bus_wr(6'h04, 32'h2);
    bus_rd(6'h04, r); chk("R4 other bit no clear", r & 32'h3, 32'h1);
    pulse_arb();
    bus_rd(6'h04, r); chk("R4 both set", r & 32'h3, 32'h3);
    bus_wr(6'h04, 32'h1);
    bus_rd(6'h04, r); chk("R4 clear done only", r & 32'h3, 32'h2);
    bus_wr(6'h04, 32'h2);
    bus_rd(6'h04, r); chk("R4 clear arb", r & 32'h3, 32'h0);

    // R5 level events ignore writes
    nack = 1'b1; need = 1'b1;
    bus_wr(6'h04, 32'hC);
    bus_rd(6'h04, r); chk("R5 levels kept", r & 32'hC, 32'hC);
    need = 1'b0; active = 1'b1;
    bus_rd(6'h04, r); chk("R3 active bit", r & 32'h2C, 32'h24);
    active = 1'b0;

    // R8 interrupt sources
    bus_wr(6'h08, 32'h04);
    @(negedge clk); chk("R8 nack irq", 32'(irq), 32'h1);
    nack = 1'b0;
    @(negedge clk); chk("R8 nack gone", 32'(irq), 32'h0);
    bus_wr(6'h08, 32'h01);
    pulse_done();
    chk("R8 done irq", 32'(irq), 32'h1);
    bus_wr(6'h04, 32'h1);
    chk("R8 done cleared", 32'(irq), 32'h0);
    bus_wr(6'h08, 32'h08);
    need = 1'b1;
    @(negedge clk); chk("R8 need irq", 32'(irq), 32'h1);
    need = 1'b0;
    bus_wr(6'h08, 32'h20);
    eng_give(8'h01); eng_give(8'h02); eng_give(8'h03);
    chk("R8 rx not full no irq", 32'(irq), 32'h0);
    eng_give(8'h04);
    chk("R8 rx full irq", 32'(irq), 32'h1);
    eng_give(8'h05);
    bus_rd(6'h18, r); chk("R2 rx full drop level", r, 32'd4);
    bus_rd(6'h20, r); chk("R11 counts dropped byte", r, 32'd7);
    bus_rd(6'h08, r); chk("R6 ctrl readback", r, 32'h20);

    // R7 soft reset
    bus_wr(6'h00, 32'h0AA);
    pulse_done();
    nack = 1'b1;
    bus_wr(6'h08, 32'h141);
    bus_rd(6'h08, r); chk("R7 reset bit reads 1", r, 32'h141);
    chk("R7 abort high", 32'(abort), 32'h1);
    bus_rd(6'h04, r); chk("R7 status during reset", r, 32'h0000_0AC0);
    bus_wr(6'h00, 32'h0BB);
    nack = 1'b0;
    repeat (RSTC + 2) @(negedge clk);
    bus_rd(6'h08, r); chk("R7 reset bit cleared", r, 32'h41);
    chk("R7 abort low", 32'(abort), 32'h0);
    bus_rd(6'h1C, r); chk("R7 tx flushed", r, 32'h0);
    bus_rd(6'h18, r); chk("R7 rx flushed", r, 32'h0);
    bus_rd(6'h20, r); chk("R7 rx count cleared", r, 32'h0);
    bus_rd(6'h24, r); chk("R7 tx count cleared", r, 32'h0);
    chk("R7 irq quiet", 32'(irq), 32'h0);

    // R12 unmapped
    bus_rd(6'h14, r); chk("R12 hole read", r, 32'h0);
    bus_rd(6'h28, r); chk("R12 beyond read", r, 32'h0);
    bus_wr(6'h14, 32'hFFFF_FFFF);
    bus_rd(6'h08, r); chk("R12 ctrl untouched", r, 32'h41);
    bus_rd(6'h0C, r); chk("R12 clk untouched", r, 32'h345);

    // random traffic against queue model
    bus_wr(6'h08, 32'hE0);
    rxcnt = 0; txcnt = 0;
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: begin
          logic [9:0] d;
          d = 10'($urandom);
          bus_wr(6'h00, {22'd0, d});
          if (txq.size() < DEPTH) txq.push_back(d);
        end
        1: begin
          eng_take(td, tv);
          chk("R1 rand valid", 32'(tv), 32'(txq.size() > 0));
          if (txq.size() > 0) begin
            chk("R1 rand data", 32'(td), 32'(txq[0]));
            void'(txq.pop_front());
            txcnt++;
          end
        end
        2: begin
          logic [7:0] d;
          d = 8'($urandom);
          eng_give(d);
          rxcnt++;
          if (rxq.size() < DEPTH) rxq.push_back(d);
        end
        default: begin
          bus_rd(6'h00, r);
          if (rxq.size() > 0) begin
            chk("R2 rand data", r, 32'(rxq[0]));
            void'(rxq.pop_front());
          end else chk("R2 rand empty", r, 32'h0);
        end
      endcase
      chk("R8 rand irq", 32'(irq), 32'(exp_irq(8'hE0, rxq.size(), txq.size())));
    end
    bus_rd(6'h18, r); chk("R10 rand rx level", r, 32'(rxq.size()));
    bus_rd(6'h1C, r); chk("R10 rand tx level", r, 32'(txq.size()));
    bus_rd(6'h20, r); chk("R11 rand rx count", r, 32'(rxcnt));
    bus_rd(6'h24, r); chk("R11 rand tx count", r, 32'(txcnt));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule